// File: doc/BRIEF.md
# Switch-Controlled Stepper Motor Sequencer

This block drives a four-phase stepper motor in full-step mode with two coils on, from a single 50 MHz system clock. Three slow switch inputs control it: a run switch, a rotation sense switch and a rate switch. Each input passes through a two-flop synchroniser. An interval timer counts clock cycles and issues one step pulse each time it reaches the selected interval. The rate switch picks the long interval (8 ms, 400,000 cycles) or the short one (2 ms, 100,000 cycles).

On each step pulse the four-bit coil pattern rotates by one position, and an eight-bit step position moves by one in the matching sense. The coil bits go to an external motor driver. The position goes to eight LEDs.

Top module: `stp_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the coil pattern becomes 0011 and the position becomes 0. The pattern is written {phase_d, phase_c, phase_b, phase_a}. The interval counter and the synchronisers also clear.
- R2: `phase_a` is coil bit 0, `phase_b` is bit 1, `phase_c` is bit 2 and `phase_d` is bit 3. After reset, `phase_a` and `phase_b` are 1 and `phase_c` and `phase_d` are 0.
- R3: With `dir_sw` = 1, each step rotates the pattern left (0011, 0110, 1100, 1001, 0011) and adds 1 to the position.
- R4: With `dir_sw` = 0, each step rotates the pattern right (0011, 1001, 1100, 0110, 0011) and subtracts 1 from the position.
- R5: The position wraps modulo 256, so 255 plus one step is 0 and 0 minus one step is 255.
- R6: With `speed_sw` = 0 and the run switch held on, steps are exactly SLOW_TICKS clock cycles apart (default 400,000).
- R7: With `speed_sw` = 1 and the run switch held on, steps are exactly FAST_TICKS clock cycles apart (default 100,000).
- R8: With `enable_sw` = 0, no step occurs and the pattern and position hold. The interval counter stays at zero, so the first step after the switch goes to 1 arrives the selected interval plus 2 cycles after the input change.
- R9: A change of the synchronised speed selection restarts the interval counter at zero and suppresses a step in that cycle. The next step arrives the new interval plus 3 cycles after the input change.
- R10: At every clock edge after reset, exactly two adjacent coils are on: the pattern is one of 0011, 0110, 1100, 1001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_sw | input | 1 | Run switch, asynchronous; 1 allows stepping |
| dir_sw | input | 1 | Rotation sense switch, asynchronous |
| speed_sw | input | 1 | Rate switch, asynchronous; 1 selects the short interval |
| phase_a | output | 1 | Coil A drive |
| phase_b | output | 1 | Coil B drive |
| phase_c | output | 1 | Coil C drive |
| phase_d | output | 1 | Coil D drive |
| position | output | POS_W | Step position for LEDs, default 8 bits |

## Verification
The assertions assume the switches are quasi-static relative to the clock. They assume at most one synchronised input changes per step interval, and that FAST_TICKS does not exceed SLOW_TICKS. The bench changes inputs only on falling edges, just after an observed step. The next step is several cycles away at that point, and the two synchroniser stages settle well before the next step decision. The bench shortens both intervals through the parameters so that the wrap and reversal sequences fit in a short run. It measures step spacing by counting cycles between observed coil changes.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef logic [3:0] coil_t;

    localparam coil_t COIL_RESET = 4'b0011;

    function automatic coil_t coil_rotate(input coil_t c, input logic left);
        coil_rotate = left ? {c[2:0], c[3]} : {c[0], c[3:1]};
    endfunction

endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/stp_interval.sv
module stp_interval #(
    parameter int SLOW_TICKS = 400000,
    parameter int FAST_TICKS = 100000,
    localparam int CNT_W     = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             fast_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fast_prev;
    } ivl_st_t;

    ivl_st_t          st_d, st_q;
    logic [CNT_W-1:0] last_val;
    logic             rate_chg;
    logic             tick;

    always_comb begin
        st_d      = st_q;
        last_val  = fast_i ? FAST_LAST : SLOW_LAST;
        rate_chg  = (fast_i != st_q.fast_prev);
        tick      = run_i && !rate_chg && (st_q.cnt == last_val);
        st_d.fast_prev = fast_i;
        if (!run_i || rate_chg || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/stp_coil_seq.sv
module stp_coil_seq
    import stp_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             left_i,
    output coil_t            coil_o,
    output logic [POS_W-1:0] pos_o
);

    typedef struct packed {
        coil_t            coil;
        logic [POS_W-1:0] pos;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.coil = coil_rotate(st_q.coil, left_i);
            if (left_i) begin
                st_d.pos = st_q.pos + 1'b1;
            end else begin
                st_d.pos = st_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.coil <= COIL_RESET;
            st_q.pos  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coil_o = st_q.coil;
    assign pos_o  = st_q.pos;

endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
    import stp_pkg::*;
#(
    parameter int SLOW_TICKS  = 400000,
    parameter int FAST_TICKS  = 100000,
    parameter int POS_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_sw,
    input  logic             dir_sw,
    input  logic             speed_sw,
    output logic             phase_a,
    output logic             phase_b,
    output logic             phase_c,
    output logic             phase_d,
    output logic [POS_W-1:0] position
);

    logic [2:0]       sw_sync;
    logic             en_s;
    logic             dir_s;
    logic             spd_s;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    coil_t            coil;

    stp_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({speed_sw, dir_sw, enable_sw}),
        .sync_o  (sw_sync)
    );

    assign en_s  = sw_sync[0];
    assign dir_s = sw_sync[1];
    assign spd_s = sw_sync[2];

    stp_interval #(
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_interval (
        .clk    (clk),
        .rst    (rst),
        .run_i  (en_s),
        .fast_i (spd_s),
        .tick_o (tick),
        .cnt_o  (cnt)
    );

    stp_coil_seq #(
        .POS_W (POS_W)
    ) u_coil (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .left_i (dir_s),
        .coil_o (coil),
        .pos_o  (position)
    );

    assign phase_a = coil[0];
    assign phase_b = coil[1];
    assign phase_c = coil[2];
    assign phase_d = coil[3];

endmodule

// File: rtl/stp_sequencer_chk.sv
module stp_sequencer_chk #(
    parameter int SLOW_TICKS = 400000,
    parameter int POS_W      = 8,
    parameter int CNT_W      = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_a,
    input logic             phase_b,
    input logic             phase_c,
    input logic             phase_d,
    input logic [POS_W-1:0] position,
    input logic             en_s,
    input logic             dir_s,
    input logic             spd_s,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);

    logic [3:0] pat;
    assign pat = {phase_d, phase_c, phase_b, phase_a};

    assert_two_adjacent_R10: assert property (@(posedge clk) disable iff (rst)
        (pat == 4'b0011 || pat == 4'b0110 || pat == 4'b1100 || pat == 4'b1001));

    assert_rotate_left_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && dir_s) |=> (pat == {$past(pat[2:0]), $past(pat[3])}));

    assert_rotate_right_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !dir_s) |=> (pat == {$past(pat[0]), $past(pat[3:1])}));

    assert_pos_up_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && dir_s) |=> (position == $past(position) + 1'b1));

    assert_pos_down_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !dir_s) |=> (position == $past(position) - 1'b1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pat) && $stable(position)));

    assert_no_step_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        !en_s |-> !tick);

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) < SLOW_TICKS));

    assert_rate_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (spd_s != $past(spd_s)) |=> (cnt == '0));

endmodule

bind stp_sequencer stp_sequencer_chk #(
    .SLOW_TICKS (SLOW_TICKS),
    .POS_W      (POS_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase_a  (phase_a),
    .phase_b  (phase_b),
    .phase_c  (phase_c),
    .phase_d  (phase_d),
    .position (position),
    .en_s     (en_s),
    .dir_s    (dir_s),
    .spd_s    (spd_s),
    .tick     (tick),
    .cnt      (cnt)
);

// File: tb/stp_sequencer_tb.sv
module stp_sequencer_tb;

    localparam int SLOW = 12;
    localparam int FAST = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable_sw = 1'b0;
    logic       dir_sw = 1'b0;
    logic       speed_sw = 1'b0;
    logic       phase_a, phase_b, phase_c, phase_d;
    logic [7:0] position;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stp_sequencer #(
        .SLOW_TICKS (SLOW),
        .FAST_TICKS (FAST)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .enable_sw (enable_sw),
        .dir_sw    (dir_sw),
        .speed_sw  (speed_sw),
        .phase_a   (phase_a),
        .phase_b   (phase_b),
        .phase_c   (phase_c),
        .phase_d   (phase_d),
        .position  (position)
    );

    typedef struct packed {
        logic       en;
        logic       dir;
        logic       spd;
        logic [3:0] steps;
        logic [3:0] coil;
        logic [7:0] pos;
        logic [7:0] ivl;
    } vec_t;

    // en, dir, spd, steps, expected coil {d,c,b,a}, expected position, last interval (0 = skip)
    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b1, 1'b0, 4'd3, 4'b1001, 8'd3,   8'd12}, // R3 R6
        '{1'b1, 1'b1, 1'b1, 4'd2, 4'b0110, 8'd5,   8'd5},  // R3 R7
        '{1'b1, 1'b0, 1'b1, 4'd3, 4'b1100, 8'd2,   8'd5},  // R4 R7
        '{1'b1, 1'b0, 1'b0, 4'd4, 4'b1100, 8'd254, 8'd12}, // R4 R5 R6
        '{1'b1, 1'b1, 1'b1, 4'd1, 4'b1001, 8'd255, 8'd0},  // R3
        '{1'b1, 1'b1, 1'b1, 4'd1, 4'b0011, 8'd0,   8'd0}   // R5
    };

    function automatic logic [3:0] coil_now();
        return {phase_d, phase_c, phase_b, phase_a};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_step(output int n);
        logic [3:0] prev;
        prev = coil_now();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (coil_now() == prev && n < 200);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1, R2: reset state and bit mapping
        check("R1 coil", int'(coil_now()), 4'b0011);
        check("R1 position", int'(position), 0);
        check("R2 phase_a", int'(phase_a), 1);
        check("R2 phase_b", int'(phase_b), 1);
        check("R2 phase_c", int'(phase_c), 0);
        check("R2 phase_d", int'(phase_d), 0);

        // R8: first step after enabling, through the synchroniser
        enable_sw = 1'b1; dir_sw = 1'b1; speed_sw = 1'b0;
        wait_step(n);
        check("R8 first-step delay", n, SLOW + 2);
        check("R3 coil", int'(coil_now()), 4'b0110);
        check("R3 position", int'(position), 1);

        // R1: reset mid-run
        enable_sw = 1'b0; dir_sw = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 coil after run", int'(coil_now()), 4'b0011);
        check("R1 position after run", int'(position), 0);

        // Table walk (R3 R4 R5 R6 R7 R10)
        foreach (VEC[i]) begin
            enable_sw = VEC[i].en;
            dir_sw    = VEC[i].dir;
            speed_sw  = VEC[i].spd;
            for (int s = 0; s < int'(VEC[i].steps); s++) begin
                wait_step(n);
            end
            check(VEC[i].dir ? "R3/R10 coil" : "R4/R10 coil",
                  int'(coil_now()), int'(VEC[i].coil));
            check("R5 position", int'(position), int'(VEC[i].pos));
            if (VEC[i].ivl != 0) begin
                check(VEC[i].spd ? "R7 interval" : "R6 interval", n, int'(VEC[i].ivl));
            end
        end

        // R8: disabled holds everything
        enable_sw = 1'b0;
        repeat (40) @(negedge clk);
        check("R8 hold coil", int'(coil_now()), 4'b0011);
        check("R8 hold position", int'(position), 0);

        // R8: re-enable at the fast rate
        enable_sw = 1'b1; dir_sw = 1'b1; speed_sw = 1'b1;
        wait_step(n);
        check("R8 fast first-step delay", n, FAST + 2);
        check("R3 coil re-enable", int'(coil_now()), 4'b0110);

        // R9: rate change restarts the counter
        repeat (2) @(negedge clk);
        speed_sw = 1'b0;
        wait_step(n);
        check("R9 restart delay", n + 2, SLOW + 3 + 2);
        check("R9 coil", int'(coil_now()), 4'b1100);
        check("R9 position", int'(position), 2);

        finish_run();
    end

endmodule